// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register Bank

This block is the register bank that software uses to set up a DRAM controller. It sits on a simple 32-bit bus with byte addresses on word boundaries. Slot 0 holds a 32-bit guard key. Slot 1 holds the controller configuration word. The slots after that are general-purpose words. Any write to a slot other than the guard key is discarded unless the guard key currently holds the unlock constant 0xFC600309. Writes to the guard key itself are always taken, so software unlocks by writing the constant and relocks by writing anything else.

The configuration word has read-only bit positions, and which positions those are depends on a hardware variant select. When the configuration word is written, those positions keep their current value. The reset value of the configuration word is built from the variant select and a two-bit RAM-size code. Read data is registered. A write that is dropped, either because the bank is locked or because the address is past the last slot, produces a one-cycle error pulse.

Top module: `dram_cfg_regbank`

## Requirements
- R1: The slot index is the byte address divided by 4, and the low two address bits are ignored. Slot 0 (byte 0x00) is the guard key, slot 1 (byte 0x04) is the configuration word, and slots 2 to NUM_REGS-1 (bytes 0x08 up to 0x1C at the default) are general words that read back what was last accepted.
- R2: `locked` is 0 exactly when the guard key holds 0xFC600309, and 1 otherwise. This includes the reset state, where the guard key is 0.
- R3: While locked, a write to any in-range slot other than slot 0 leaves that slot unchanged.
- R4: A write to slot 0 is accepted in both the locked and the unlocked state. Writing any value other than 0xFC600309 relocks the bank.
- R5: With variant_sel=0 (variant A), the configuration bits 31:11, bit 6 and bits 3:2 are read-only and keep their value on a write. All other bits take the written data.
- R6: With variant_sel=1 (variant B), the configuration bits 31:28, 19, 18:14, 6 and 3:2 are read-only and keep their value on a write. All other bits take the written data.
- R7: While reset is held with variant A, every slot is 0 except the configuration word, which is 0x40 OR size_code. Bits 1:0 hold the size code: 0=64MB, 1=128MB, 2=256MB, 3=512MB.
- R8: While reset is held with variant B, every slot is 0 except the configuration word, which is 0x1000000C OR size_code. This gives hardware version 1 in bits 31:28 and aperture 3 in bits 3:2. The size code in bits 1:0 means 0=128MB, 1=256MB, 2=512MB, 3=1024MB.
- R9: A read at or beyond slot NUM_REGS returns 0. A write there changes no slot, including slot 0 that it would alias to with the high bits dropped.
- R10: `wr_err` is high for the one cycle after a clock edge that samples a dropped write (locked, or out of range). It stays low after an accepted write or a read.
- R11: `rdata` shows the addressed slot in the cycle after the edge that samples `rd_en`. A write is visible to a read issued on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_sel | input | 1 | Hardware variant: 0 = A, 1 = B |
| size_code | input | 2 | RAM-size code loaded into configuration bits 1:0 at reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| locked | output | 1 | High while the guard key does not hold the unlock constant |
| wr_err | output | 1 | One-cycle pulse after a dropped write |

## Verification
The hardest case to reach from the ports is a configuration write that actually changes the stored read-only bits, because those bits only get their value at reset. The bench therefore resets the bank under both variants and several size codes. It unlocks, writes all-ones and then all-zeros, and compares each read-back against a merge of the prior value and the write data that the bench computes from the mask of that variant. An out-of-range write whose low index bits alias slot 0 is sent with the unlock constant, so that a decode which drops the high bits would visibly unlock a bank that should stay locked.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

    // read-only masks of the configuration word per variant
    localparam logic [31:0] CFG_RO_MASK_A = 32'hFFFF_F84C;
    localparam logic [31:0] CFG_RO_MASK_B = 32'hF00F_C04C;

    // fixed fields loaded at reset per variant
    localparam logic [31:0] CFG_RST_BASE_A = 32'h0000_0040;
    localparam logic [31:0] CFG_RST_BASE_B = 32'h1000_000C;

    typedef enum logic {
        VARIANT_A = 1'b0,
        VARIANT_B = 1'b1
    } variant_e;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                in_range
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             unused_lo;

    assign idx       = addr[ADDR_W-1:2];
    assign unused_lo = ^addr[1:0];
    assign in_range  = (32'(idx) < 32'(NUM_REGS));

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_sel
            assign sel[g] = in_range && (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/regbank_guard.sv
module regbank_guard
    import regbank_pkg::*;
(
    input  logic [31:0] key_q,
    input  logic        wr_en,
    input  logic        in_range,
    input  logic        hit_key,
    output logic        locked,
    output logic        wr_ok,
    output logic        wr_drop
);
    assign locked  = (key_q != UNLOCK_KEY);
    assign wr_ok   = wr_en && in_range && (hit_key || !locked);
    assign wr_drop = wr_en && !wr_ok;
endmodule

// File: rtl/regbank_cfg_merge.sv
module regbank_cfg_merge
    import regbank_pkg::*;
(
    input  logic        variant_sel,
    input  logic [1:0]  size_code,
    input  logic [31:0] cfg_q,
    input  logic [31:0] wdata,
    output logic [31:0] cfg_rst,
    output logic [31:0] cfg_wr
);
    logic [31:0] ro_mask;
    logic [31:0] base;

    always_comb begin
        unique case (variant_e'(variant_sel))
            VARIANT_A: begin
                ro_mask = CFG_RO_MASK_A;
                base    = CFG_RST_BASE_A;
            end
            default: begin
                ro_mask = CFG_RO_MASK_B;
                base    = CFG_RST_BASE_B;
            end
        endcase
        cfg_rst = base | {30'd0, size_code};
        cfg_wr  = (cfg_q & ro_mask) | (wdata & ~ro_mask);
    end
endmodule

// File: rtl/dram_cfg_regbank.sv
module dram_cfg_regbank
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_sel,
    input  logic [1:0]        size_code,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              locked,
    output logic              wr_err
);
    localparam int NUM_GEN = NUM_REGS - 2;

    typedef struct packed {
        logic [31:0]              key;
        logic [31:0]              cfg;
        logic [NUM_GEN-1:0][31:0] gen;
        logic [31:0]              rdata;
        logic                     err;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_REGS-1:0] sel;
    logic                in_range;
    logic                wr_ok;
    logic                wr_drop;
    logic [31:0]         cfg_rst;
    logic [31:0]         cfg_wr;
    logic [31:0]         rd_word;
    logic [31:0]         cfg_cur;

    regbank_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .addr     (addr),
        .sel      (sel),
        .in_range (in_range)
    );

    regbank_guard u_guard (
        .key_q    (st_q.key),
        .wr_en    (wr_en),
        .in_range (in_range),
        .hit_key  (sel[0]),
        .locked   (locked),
        .wr_ok    (wr_ok),
        .wr_drop  (wr_drop)
    );

    regbank_cfg_merge u_cfg (
        .variant_sel (variant_sel),
        .size_code   (size_code),
        .cfg_q       (st_q.cfg),
        .wdata       (wdata),
        .cfg_rst     (cfg_rst),
        .cfg_wr      (cfg_wr)
    );

    // read multiplexer: zero when nothing in range is selected
    always_comb begin
        rd_word = '0;
        if (sel[0]) rd_word = st_q.key;
        if (sel[1]) rd_word = st_q.cfg;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (sel[i+2]) rd_word = st_q.gen[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = wr_drop;
        if (wr_ok) begin
            if (sel[0]) st_d.key = wdata;
            if (sel[1]) st_d.cfg = cfg_wr;
            for (int i = 0; i < NUM_GEN; i++) begin
                if (sel[i+2]) st_d.gen[i] = wdata;
            end
        end
        if (rd_en) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= cfg_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign wr_err  = st_q.err;
    assign cfg_cur = st_q.cfg;
endmodule

// File: rtl/dram_cfg_regbank_checker.sv
module dram_cfg_regbank_checker
    import regbank_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              variant_sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              locked,
    input logic              wr_err,
    input logic [31:0]       cfg_cur
);
    logic [ADDR_W-3:0] idx;
    logic              oor;
    assign idx = addr[ADDR_W-1:2];
    assign oor = (32'(idx) >= 32'(NUM_REGS));

    AST_UNLOCK_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && idx == '0 && wdata == UNLOCK_KEY |=> !locked); // R2
    AST_RELOCK_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && idx == '0 && wdata != UNLOCK_KEY |=> locked); // R4
    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && locked && idx != '0 |=> wr_err && locked && $stable(cfg_cur)); // R3
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && oor |=> rdata == 32'd0); // R9
    AST_OOR_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && oor |=> wr_err); // R10
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err); // R10
    AST_RO_KEPT_A: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !locked && idx == 1 && !variant_sel
        |=> ((cfg_cur ^ $past(cfg_cur)) & CFG_RO_MASK_A) == 32'd0); // R5
    AST_RW_TAKEN_A: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !locked && idx == 1 && !variant_sel
        |=> (cfg_cur & ~CFG_RO_MASK_A) == ($past(wdata) & ~CFG_RO_MASK_A)); // R5
    AST_RO_KEPT_B: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !locked && idx == 1 && variant_sel
        |=> ((cfg_cur ^ $past(cfg_cur)) & CFG_RO_MASK_B) == 32'd0); // R6
endmodule

bind dram_cfg_regbank dram_cfg_regbank_checker #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .variant_sel (variant_sel),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .locked      (locked),
    .wr_err      (wr_err),
    .cfg_cur     (cfg_cur)
);

// File: tb/dram_cfg_regbank_bench.sv
module dram_cfg_regbank_bench;
    localparam int AW = 12;
    localparam logic [31:0] KEY   = 32'hFC60_0309;
    localparam logic [31:0] MSK_A = 32'hFFFF_F84C;
    localparam logic [31:0] MSK_B = 32'hF00F_C04C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          variant_sel = 1'b0;
    logic [1:0]    size_code = 2'd0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          locked;
    logic          wr_err;

    int n_run  = 0;
    int n_fail = 0;
    logic last_err;

    always #5 clk = ~clk;

    dram_cfg_regbank u_dram_cfg_regbank (
        .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel), .size_code(size_code),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .locked(locked), .wr_err(wr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic v, input logic [1:0] sz);
        @(negedge clk);
        variant_sel = v;
        size_code   = sz;
        rst_n       = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        last_err = wr_err;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp);
        check({req, " err"}, {31'd0, wr_err}, 32'd0);
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [31:0] m);
        return (old & m) | (d & ~m);
    endfunction

    task automatic t_reset_a();
        do_reset(1'b0, 2'd2);
        check("R7 locked after reset", {31'd0, locked}, 32'd1);
        rd(12'h004, 32'h0000_0042, "R7 cfg reset A");
        rd(12'h000, 32'h0, "R7 key reset");
        rd(12'h010, 32'h0, "R7 gen reset");
        do_reset(1'b0, 2'd0);
        rd(12'h004, 32'h0000_0040, "R7 cfg reset A size0");
    endtask

    task automatic t_locked_drop();
        wr(12'h004, 32'hFFFF_FFFF);
        check("R10 err on locked write", {31'd0, last_err}, 32'd1);
        rd(12'h004, 32'h0000_0040, "R3 cfg unchanged");
        wr(12'h008, 32'hDEAD_BEEF);
        check("R10 err on locked gen write", {31'd0, last_err}, 32'd1);
        rd(12'h008, 32'h0, "R3 gen unchanged");
    endtask

    task automatic t_unlock_and_rw();
        wr(12'h000, KEY);
        check("R4 key write accepted no err", {31'd0, last_err}, 32'd0);
        check("R2 unlocked", {31'd0, locked}, 32'd0);
        rd(12'h000, KEY, "R4 key readback");
        wr(12'h004, 32'hFFFF_FFFF);
        check("R10 no err accepted", {31'd0, last_err}, 32'd0);
        rd(12'h004, merge(32'h40, 32'hFFFF_FFFF, MSK_A), "R5 cfg ones A");
        wr(12'h004, 32'h0);
        rd(12'h004, merge(32'h7F3, 32'h0, MSK_A), "R5 cfg zeros A");
        wr(12'h008, 32'h1234_5678);
        rd(12'h008, 32'h1234_5678, "R11 gen first");
        wr(12'h01D, 32'hA5A5_0F0F);
        rd(12'h01C, 32'hA5A5_0F0F, "R1 gen last, low bits ignored");
        rd(12'h00B, 32'h1234_5678, "R1 unaligned read");
    endtask

    task automatic t_out_of_range();
        rd(12'h020, 32'h0, "R9 oor read");
        rd(12'hFFC, 32'h0, "R9 top read");
        wr(12'h020, 32'h0);
        check("R10 oor write err", {31'd0, last_err}, 32'd1);
        check("R9 oor write no relock", {31'd0, locked}, 32'd0);
        rd(12'h000, KEY, "R9 key intact");
        rd(12'h01C, 32'hA5A5_0F0F, "R9 gen intact");
    endtask

    task automatic t_relock();
        wr(12'h000, 32'h1234_5678);
        check("R4 relock", {31'd0, locked}, 32'd1);
        wr(12'h008, 32'h0);
        rd(12'h008, 32'h1234_5678, "R3 drop after relock");
        wr(12'h040, KEY);
        check("R9 aliased oor write keeps lock", {31'd0, locked}, 32'd1);
    endtask

    task automatic t_variant_b();
        do_reset(1'b1, 2'd1);
        check("R8 locked after reset B", {31'd0, locked}, 32'd1);
        rd(12'h004, 32'h1000_000D, "R8 cfg reset B");
        wr(12'h000, KEY);
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, merge(32'h1000_000D, 32'hFFFF_FFFF, MSK_B), "R6 cfg ones B");
        wr(12'h004, 32'h0);
        rd(12'h004, merge(32'h1FF0_3FBF, 32'h0, MSK_B), "R6 cfg zeros B");
        do_reset(1'b1, 2'd3);
        rd(12'h004, 32'h1000_000F, "R8 cfg reset B size3");
        rd(12'h008, 32'h0, "R8 gen reset B");
    endtask

    initial begin
        t_reset_a();
        t_locked_drop();
        t_unlock_and_rw();
        t_out_of_range();
        t_relock();
        t_variant_b();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule